// File: doc/BRIEF.md
# Keyed-Write Watchdog Reset Controller

This block is a watchdog that sits on a small 16-bit register bus. An 8-bit up-counter advances on a one-cycle tick input while the timer-enable bit of its control byte is set. When the counter wraps from 0xFF to 0x00, the block issues a chip-wide reset that lasts a fixed number of cycles. It records the event in a sticky status flag, and it can also drive an active-low reset pin for devices outside the chip.

The counter and the control byte share one bus address. They accept only full 16-bit writes. The upper byte of the write is a key that selects which register receives the lower byte, and a write with the wrong key does nothing. The status flag cannot be cleared by a single write: software must first read it as 1 and then write 0 to it. The flag and the output-enable bit live through the block's own reset pulse, and only the external power-on reset clears them.

Top module: `wdog_rstctl`

## Requirements
- R1: A write to address 0 with both byte enables (be=2'b11) and upper byte 0x5A loads the lower byte into the counter, which reads back at address 1 (bits 7:0).
- R2: A write to address 0 with be=2'b11 and upper byte 0xA5 loads the lower byte into the control byte, which reads back at address 0 (bits 7:0).
- R3: At address 0, a write with any other upper byte, or with be other than 2'b11, changes neither the counter nor the control byte.
- R4: On each cycle with tick=1, the counter increments by one only if control bit 5 is 1. A keyed counter load in the same cycle takes priority over the tick.
- R5: When the counter wraps from 0xFF to 0x00 on a tick, chip_rst is high for exactly 16 cycles, starting in the cycle after the wrap. Counter and control byte are 0 afterwards.
- R6: The wrap sets the reset flag, which is bit 7 of the status byte at address 2.
- R7: The flag clears only when a status write with bit 7 = 0 follows a bus read of address 2 that returned the flag as 1. Any status write disarms that read. A wrap in the same cycle as a clearing write leaves the flag set.
- R8: A status write with be[0]=1 sets the output enable from bit 6. ext_rst_n is low exactly while chip_rst is high and the output enable is 1.
- R9: Status bits 5:0 always read as 1, and bits 15:8 of every read are 0.
- R10: rst clears the counter, the control byte, the flag and the output enable. The flag and the output enable survive chip_rst.
- R11: While chip_rst is high, all bus writes and reads have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | External power-on reset, synchronous, active high |
| tick | input | 1 | One-cycle count enable |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_addr | input | 2 | 0 keyed counter/control, 1 counter, 2 status |
| bus_be | input | 2 | Byte enables, bit 1 = upper byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| chip_rst | output | 1 | Internal reset pulse, active high |
| ext_rst_n | output | 1 | External reset, active low |

## Verification
Two pairs of functions can fall in the same cycle. A keyed counter load can coincide with a tick, and a flag-clearing write can coincide with the counter wrap that sets the flag. The bench provokes each pair by driving both stimuli at one clock edge. For the first pair, it judges the result by reading back the loaded counter value. For the second, it checks that the flag is still set once the resulting pulse ends, and that a later clearing write with no new read leaves the flag untouched.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] KEY_CNT  = 8'h5A;
    localparam logic [BYTE_W-1:0] KEY_CTRL = 8'hA5;
    localparam int EN_BIT = 5;

    typedef enum logic [1:0] {
        A_KEYED = 2'd0,
        A_COUNT = 2'd1,
        A_RSTAT = 2'd2,
        A_SPARE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              ld_cnt;
        logic              ld_ctrl;
        logic              rs_wr;
        logic              rs_rd;
        logic [BYTE_W-1:0] data;
    } bus_cmd_t;

    typedef struct packed {
        logic flag;
        logic oe;
    } rstat_t;

    function automatic logic [BYTE_W-1:0] rstat_byte(rstat_t s);
        return {s.flag, s.oe, 6'h3F};
    endfunction

endpackage

// File: rtl/wdog_busif.sv
module wdog_busif
    import wdog_pkg::*;
(
    input  logic              blocked,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_cmd_t          cmd
);

    always_comb begin
        cmd      = '0;
        cmd.data = bus_wdata[BYTE_W-1:0];
        if (!blocked) begin
            case (reg_addr_e'(bus_addr))
                A_KEYED: begin
                    if (bus_wr && bus_be == 2'b11) begin
                        if (bus_wdata[DATA_W-1:BYTE_W] == KEY_CNT)
                            cmd.ld_cnt = 1'b1;
                        else if (bus_wdata[DATA_W-1:BYTE_W] == KEY_CTRL)
                            cmd.ld_ctrl = 1'b1;
                    end
                end
                A_RSTAT: begin
                    cmd.rs_wr = bus_wr && bus_be[0];
                    cmd.rs_rd = bus_rd;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    input  logic              ld_cnt,
    input  logic              ld_ctrl,
    input  logic [BYTE_W-1:0] data,
    output logic [CNT_W-1:0]  cnt,
    output logic [BYTE_W-1:0] ctrl,
    output logic              ovf
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic run;
    assign run = tick && ctrl[EN_BIT] && !clr;
    assign ovf = run && !ld_cnt && (cnt == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            ctrl <= '0;
        end else begin
            if (ld_ctrl)
                ctrl <= data;
            if (ld_cnt)
                cnt <= CNT_W'(data);
            else if (run)
                cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !ld_cnt) |=> cnt == CNT_W'($past(cnt) + 1'b1));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);

    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= CW'(LEN);
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign active = (remain != '0);

endmodule

// File: rtl/wdog_rststat.sv
module wdog_rststat
    import wdog_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   set,
    input  logic   wr,
    input  logic   rd,
    input  logic   w_flag,
    input  logic   w_oe,
    output rstat_t st
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            armed <= 1'b0;
        end else begin
            if (wr) begin
                st.oe <= w_oe;
                armed <= 1'b0;
                if (armed && !w_flag)
                    st.flag <= 1'b0;
            end else if (rd && st.flag) begin
                armed <= 1'b1;
            end
            if (set)
                st.flag <= 1'b1;
        end
    end

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(st.flag) |-> ($past(armed) && $past(wr) && !$past(w_flag)));

endmodule

// File: rtl/wdog_rstctl.sv
module wdog_rstctl
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        chip_rst,
    output logic        ext_rst_n
);

    localparam int HOLD_W = $clog2(PULSE_LEN + 2);

    bus_cmd_t          cmd;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] ctrl;
    logic              ovf;
    rstat_t            st;

    wdog_busif u_busif (
        .blocked   (chip_rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .cmd       (cmd)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .clr     (chip_rst),
        .tick    (tick),
        .ld_cnt  (cmd.ld_cnt),
        .ld_ctrl (cmd.ld_ctrl),
        .data    (cmd.data),
        .cnt     (cnt),
        .ctrl    (ctrl),
        .ovf     (ovf)
    );

    wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .start  (ovf),
        .active (chip_rst)
    );

    wdog_rststat u_rststat (
        .clk    (clk),
        .rst    (rst),
        .set    (ovf),
        .wr     (cmd.rs_wr),
        .rd     (cmd.rs_rd),
        .w_flag (cmd.data[7]),
        .w_oe   (cmd.data[6]),
        .st     (st)
    );

    assign ext_rst_n = !(chip_rst && st.oe);

    always_comb begin
        case (reg_addr_e'(bus_addr))
            A_KEYED: bus_rdata = {8'h00, ctrl};
            A_COUNT: bus_rdata = {8'h00, 8'(cnt)};
            A_RSTAT: bus_rdata = {8'h00, rstat_byte(st)};
            default: bus_rdata = '0;
        endcase
    end

    // Length of the current chip_rst run, used to check the pulse width.
    logic [HOLD_W-1:0] hold_cnt;
    always_ff @(posedge clk) begin
        if (rst || !chip_rst)
            hold_cnt <= '0;
        else if (hold_cnt != '1)
            hold_cnt <= hold_cnt + 1'b1;
    end

    assert_pulse_len_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_rst) |-> hold_cnt == HOLD_W'(PULSE_LEN));

    assert_ovf_flag_R6: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (st.flag && chip_rst));

    assert_status_hold_R11: assert property (@(posedge clk) disable iff (rst)
        chip_rst |=> $stable(st));

    assert_ignore_partial_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0 && bus_be != 2'b11 && !chip_rst && !ovf)
        |=> $stable(ctrl));

endmodule

// File: tb/wdog_rstctl_bench.sv
module wdog_rstctl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        chip_rst;
    logic        ext_rst_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdog_rstctl u_wdog_rstctl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .chip_rst  (chip_rst),
        .ext_rst_n (ext_rst_n)
    );

    // {be, wdata, expected control, expected counter}; writes to address 0, no tick
    localparam int NVEC = 10;
    localparam logic [33:0] VEC [NVEC] = '{
        {2'b11, 16'h5A37, 8'h00, 8'h37},   // R1
        {2'b11, 16'hA5C4, 8'hC4, 8'h37},   // R2
        {2'b01, 16'h5A99, 8'hC4, 8'h37},   // R3 low byte only
        {2'b10, 16'hA511, 8'hC4, 8'h37},   // R3 high byte only
        {2'b11, 16'h3C55, 8'hC4, 8'h37},   // R3 wrong key
        {2'b11, 16'h5A00, 8'hC4, 8'h00},   // R1
        {2'b11, 16'hA55A, 8'h5A, 8'h00},   // R2
        {2'b11, 16'h5AFE, 8'h5A, 8'hFE},   // R1
        {2'b11, 16'hA5A5, 8'hA5, 8'hFE},   // R2
        {2'b11, 16'hA500, 8'h00, 8'hFE}    // R2
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 2'b00;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic measure(input logic exp_oe, output int n);
        n = 0;
        while (chip_rst && n < 100) begin
            n++;
            chk("R8 ext_rst_n in pulse", 16'(ext_rst_n), 16'(!exp_oe));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 / R9: reset state
        peek(2'd0, v); chk("R10 ctrl after rst", v, 16'h0000);
        peek(2'd1, v); chk("R10 cnt after rst", v, 16'h0000);
        peek(2'd2, v); chk("R9 status after rst", v, 16'h003F);
        chk("R10 chip_rst idle", 16'(chip_rst), 16'h0001 ^ 16'h0001);
        chk("R8 ext_rst_n idle", 16'(ext_rst_n), 16'h0001);

        // R1 R2 R3: keyed-write table
        for (int i = 0; i < NVEC; i++) begin
            bus_write(2'd0, VEC[i][33:32], VEC[i][31:16]);
            peek(2'd0, v); chk($sformatf("R1/R2/R3 vec%0d ctrl", i), v, {8'h00, VEC[i][15:8]});
            peek(2'd1, v); chk($sformatf("R1/R2/R3 vec%0d cnt", i), v, {8'h00, VEC[i][7:0]});
        end

        // R4: tick while disabled, then enabled, then load versus tick
        bus_write(2'd0, 2'b11, 16'h5A10);
        repeat (3) do_tick();
        peek(2'd1, v); chk("R4 no count when disabled", v, 16'h0010);
        bus_write(2'd0, 2'b11, 16'hA520);
        repeat (3) do_tick();
        peek(2'd1, v); chk("R4 count when enabled", v, 16'h0013);
        tick = 1'b1;
        bus_write(2'd0, 2'b11, 16'h5A80);
        tick = 1'b0;
        peek(2'd1, v); chk("R4 load beats tick", v, 16'h0080);

        // R8: set output enable; R5 R6: first overflow
        bus_write(2'd2, 2'b01, 16'h0040);
        peek(2'd2, v); chk("R8 oe set", v, 16'h007F);
        bus_write(2'd0, 2'b11, 16'h5AFF);
        do_tick();
        measure(1'b1, n);
        chk("R5 pulse length", 16'(n), 16'd16);
        peek(2'd0, v); chk("R5 ctrl cleared", v, 16'h0000);
        peek(2'd1, v); chk("R5 cnt cleared", v, 16'h0000);
        peek(2'd2, v); chk("R6 R10 flag and oe survive", v, 16'h00FF);

        // R7: clear without read is ignored; read then clear works
        bus_write(2'd2, 2'b01, 16'h0040);
        peek(2'd2, v); chk("R7 clear without read", v, 16'h00FF);
        bus_read(2'd2, v); chk("R7 arming read", v, 16'h00FF);
        bus_write(2'd2, 2'b01, 16'h0000);
        peek(2'd2, v); chk("R7 flag cleared", v, 16'h003F);

        // R8 R11: overflow with oe off, bus activity during pulse
        bus_write(2'd0, 2'b11, 16'h5AFF);
        bus_write(2'd0, 2'b11, 16'hA520);
        do_tick();
        chk("R5 pulse started", 16'(chip_rst), 16'h0001);
        chk("R8 ext_rst_n high with oe off", 16'(ext_rst_n), 16'h0001);
        bus_write(2'd0, 2'b11, 16'h5A33);
        bus_write(2'd2, 2'b01, 16'h0040);
        measure(1'b0, n);
        chk("R5 pulse length second", 16'(n + 2), 16'd16);
        peek(2'd1, v); chk("R11 cnt write ignored", v, 16'h0000);
        peek(2'd2, v); chk("R11 status write ignored", v, 16'h00BF);

        // R7: clearing write and overflow in the same cycle
        bus_read(2'd2, v); chk("R7 arm before race", v, 16'h00BF);
        bus_write(2'd0, 2'b11, 16'h5AFF);
        bus_write(2'd0, 2'b11, 16'hA520);
        tick = 1'b1;
        bus_write(2'd2, 2'b01, 16'h0000);
        tick = 1'b0;
        measure(1'b0, n);
        chk("R5 pulse length race", 16'(n), 16'd16);
        peek(2'd2, v); chk("R7 set wins over clear", v, 16'h00BF);
        bus_write(2'd2, 2'b01, 16'h0000);
        peek(2'd2, v); chk("R7 disarmed after write", v, 16'h00BF);

        // R10: external reset clears everything
        bus_write(2'd2, 2'b01, 16'h0040);
        bus_write(2'd0, 2'b11, 16'h5A44);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        peek(2'd2, v); chk("R10 status after rst", v, 16'h003F);
        peek(2'd1, v); chk("R10 cnt after rst", v, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule